// File: doc/BRIEF.md
# Sticky Floating-Point Exception Flag Bank

This block holds the five IEEE 754 exception status flags that sit beside a floating-point unit. Each cycle the datapath raises a detect pulse for any of invalid operation, overflow, division by zero, underflow and inexact. For each exception, a per-exception enable bit chooses what the pulse does. When the exception is masked (enable 0), the pulse sets its flag. When the exception is enabled (enable 1), the pulse raises a one-cycle trap request and the flag keeps its value.

Flags accumulate. A flag that has been set stays set until software writes a 0 to it. A read port returns a status word made of the five flags plus a summary error bit. The summary bit is the OR of every flag except inexact. Software loads the flags and the enable bits through a shared write data bus, with one strobe for each register.

Top module: `fpx_flag_bank`

## Requirements
- R1: After reset, the flags, the enable bits, the summary bit and all trap requests are 0.
- R2: A detect pulse for a masked exception (enable 0) sets that flag, and the flag is visible on the cycle after the clock edge that samples the pulse. Status word layout: bit 0 invalid, bit 1 overflow, bit 2 division by zero, bit 3 underflow, bit 4 inexact, bit 5 summary.
- R3: A detect pulse for an enabled exception (enable 1) leaves that flag unchanged.
- R4: With no flag write, a set flag stays 1 through any number of cycles. It is cleared only when software writes 0 to its bit.
- R5: The summary bit is the OR of status bits 0 to 3. The inexact flag (bit 4) does not affect it.
- R6: A detect pulse for an enabled exception raises that exception's trap bit (same bit order as the flags) for exactly the next cycle.
- R7: A software write to status bit 5 is ignored. The summary always follows the stored flags.
- R8: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends at 1.
- R9: Several masked exceptions detected in one cycle all set their flags together.
- R10: A flag write strobe loads wr_data[4:0] into the flags. An enable write strobe loads wr_data[4:0] into the enable bits. A detect in the same cycle as an enable write uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_i | input | 5 | Per-cycle exception detect pulses |
| flag_we | input | 1 | Load flags from wr_data[4:0] |
| ena_we | input | 1 | Load enable bits from wr_data[4:0] |
| wr_data | input | 6 | Software write data, status word layout |
| status_o | output | 6 | Read port: {summary, flags} |
| flags_o | output | 5 | Stored flags |
| summary_o | output | 1 | Summary error bit |
| ena_o | output | 5 | Stored enable bits |
| trap_o | output | 5 | One-cycle trap requests |

## Verification
The assertions assume detect pulses and write strobes are synchronous to the clock and are stable around the sampling edge. They also assume the write data is meaningful only while a strobe is high. The bench changes every input on the falling edge, so each edge sees settled values. It drives combinations that include simultaneous detects, detects that coincide with flag writes and with enable writes, and writes of 1 to the summary position.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int unsigned NUM_EXC   = 5;
   localparam int unsigned STATUS_W  = NUM_EXC + 1;
   localparam int unsigned IDX_INV   = 0;
   localparam int unsigned IDX_OVF   = 1;
   localparam int unsigned IDX_DVZ   = 2;
   localparam int unsigned IDX_UNF   = 3;
   localparam int unsigned IDX_INX   = 4;
   localparam int unsigned IDX_SUM   = NUM_EXC;
   // flags that feed the summary bit: all but inexact
   localparam logic [NUM_EXC-1:0] SUM_MASK = 5'b01111;
   typedef logic [NUM_EXC-1:0] exc_vec_t;
endpackage

// File: rtl/fpx_sticky_bit.sv
module fpx_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_we,
   input  logic sw_val,
   output logic q
);
   logic q_n;

   // hardware set has priority over any software value
   always_comb begin
      q_n = q;
      if (sw_we)  q_n = sw_val;
      if (hw_set) q_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_n;
   end
endmodule

// File: rtl/fpx_mask_reg.sv
module fpx_mask_reg #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/fpx_err_summary.sv
module fpx_err_summary #(
   parameter int unsigned           N    = 5,
   parameter logic [N-1:0]          MASK = '1
) (
   input  logic [N-1:0] flags,
   output logic         summary
);
   assign summary = |(flags & MASK);
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
   import fpx_pkg::*;
#(
   parameter int unsigned N        = NUM_EXC,
   parameter bit          TRAP_REG = 1'b1,
   localparam int unsigned SW      = N + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  det_i,
   input  logic          flag_we,
   input  logic          ena_we,
   input  logic [SW-1:0] wr_data,
   output logic [SW-1:0] status_o,
   output logic [N-1:0]  flags_o,
   output logic          summary_o,
   output logic [N-1:0]  ena_o,
   output logic [N-1:0]  trap_o
);
   generate
      if (N != NUM_EXC) begin : g_bad_n
         $error("fpx_flag_bank: N must equal the IEEE 754 exception count");
      end
      if (SW != STATUS_W) begin : g_bad_sw
         $error("fpx_flag_bank: status width mismatch");
      end
   endgenerate

   logic [N-1:0] ena_q;
   logic [N-1:0] masked_hit;
   logic [N-1:0] trap_hit;

   fpx_mask_reg #(.W(N)) u_ena (
      .clk(clk), .rst_n(rst_n), .we(ena_we), .d(wr_data[N-1:0]), .q(ena_q)
   );

   assign masked_hit = det_i & ~ena_q;
   assign trap_hit   = det_i &  ena_q;

   for (genvar i = 0; i < N; i++) begin : g_flag
      fpx_sticky_bit u_bit (
         .clk(clk), .rst_n(rst_n),
         .hw_set(masked_hit[i]),
         .sw_we(flag_we),
         .sw_val(wr_data[i]),
         .q(flags_o[i])
      );
   end

   fpx_err_summary #(.N(N), .MASK(SUM_MASK)) u_sum (
      .flags(flags_o), .summary(summary_o)
   );

   generate
      if (TRAP_REG) begin : g_trap_ff
         logic [N-1:0] trap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trap_q <= '0;
            else        trap_q <= trap_hit;
         end
         assign trap_o = trap_q;
      end else begin : g_trap_comb
         assign trap_o = trap_hit;
      end
   endgenerate

   assign ena_o    = ena_q;
   assign status_o = {summary_o, flags_o};
endmodule

// File: rtl/fpx_flag_bank_chk.sv
module fpx_flag_bank_chk #(
   parameter int unsigned N  = 5,
   parameter int unsigned SW = N + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  det_i,
   input logic          flag_we,
   input logic          ena_we,
   input logic [SW-1:0] wr_data,
   input logic [SW-1:0] status_o,
   input logic [N-1:0]  flags_o,
   input logic          summary_o,
   input logic [N-1:0]  ena_o,
   input logic [N-1:0]  trap_o
);
   p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_o & $past(det_i & ~ena_o)) == $past(det_i & ~ena_o)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> (flags_o == ($past(flags_o) | $past(det_i & ~ena_o))));

   p_enabled_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> ((flags_o & $past(det_i & ena_o)) == ($past(flags_o) & $past(det_i & ena_o))));

   p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[N] == |status_o[3:0]);

   p_trap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (trap_o == $past(det_i & ena_o)));

   p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flags_o == ($past(wr_data[N-1:0]) | $past(det_i & ~ena_o))));

   p_ena_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ena_we |=> (ena_o == $past(wr_data[N-1:0])));
endmodule

bind fpx_flag_bank fpx_flag_bank_chk #(.N(N), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .det_i(det_i), .flag_we(flag_we),
   .ena_we(ena_we), .wr_data(wr_data), .status_o(status_o),
   .flags_o(flags_o), .summary_o(summary_o), .ena_o(ena_o), .trap_o(trap_o)
);

// File: tb/test_fpx_flag_bank.sv
module test_fpx_flag_bank;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] det_i = '0;
   logic       flag_we = 1'b0;
   logic       ena_we = 1'b0;
   logic [5:0] wr_data = '0;
   logic [5:0] status_o;
   logic [4:0] flags_o;
   logic       summary_o;
   logic [4:0] ena_o;
   logic [4:0] trap_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [4:0] flags;
      logic [4:0] ena;
      logic [4:0] trap;
      string      tag;
   } exp_t;

   exp_t q_exp[$];

   logic [4:0] m_flags = '0;
   logic [4:0] m_ena = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_flag_bank i_fpx_flag_bank (
      .clk(clk), .rst_n(rst_n), .det_i(det_i), .flag_we(flag_we),
      .ena_we(ena_we), .wr_data(wr_data), .status_o(status_o),
      .flags_o(flags_o), .summary_o(summary_o), .ena_o(ena_o), .trap_o(trap_o)
   );

   task automatic cmp(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, push the predicted result
   task automatic step(input logic [4:0] det, input logic fwe, input logic ewe,
                       input logic [5:0] data, input string tag);
      exp_t e;
      logic [4:0] set_v;
      @(negedge clk);
      det_i = det; flag_we = fwe; ena_we = ewe; wr_data = data;
      set_v   = det & ~m_ena;
      e.trap  = det & m_ena;
      m_flags = set_v | (fwe ? data[4:0] : m_flags);
      if (ewe) m_ena = data[4:0];
      e.flags = m_flags;
      e.ena   = m_ena;
      e.tag   = tag;
      @(posedge clk);
      #1;
      q_exp.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(5'b0, 1'b0, 1'b0, 6'b0, tag);
   endtask

   // monitor: compare outputs against the oldest prediction
   initial begin
      forever begin
         @(negedge clk);
         if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            cmp(e.tag, "flags", {1'b0, flags_o}, {1'b0, e.flags});
            cmp(e.tag, "status", status_o, {|e.flags[3:0], e.flags});
            cmp(e.tag, "enable", {1'b0, ena_o}, {1'b0, e.ena});
            cmp(e.tag, "trap", {1'b0, trap_o}, {1'b0, e.trap});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "status", status_o, 6'b0);
      cmp("R1", "enable", {1'b0, ena_o}, 6'b0);
      cmp("R1", "trap", {1'b0, trap_o}, 6'b0);
      rst_n = 1'b1;

      // R2: single masked detect, invalid operation
      step(5'b00001, 1'b0, 1'b0, 6'b0, "R2");
      // R4: flag holds through idle cycles
      idle("R4");
      idle("R4");
      // R5: inexact alone does not raise summary
      step(5'b0, 1'b1, 1'b0, 6'b010000, "R5");
      idle("R5");
      // R9: several masked detects at once
      step(5'b01110, 1'b0, 1'b0, 6'b0, "R9");
      // R4: clear only by software write of 0
      step(5'b0, 1'b1, 1'b0, 6'b000000, "R4");
      // R7: write to summary position ignored
      step(5'b0, 1'b1, 1'b0, 6'b100000, "R7");
      idle("R7");
      step(5'b0, 1'b1, 1'b0, 6'b110000, "R7");
      // R10: enable load, detect same cycle uses old enable
      step(5'b00010, 1'b0, 1'b1, 6'b000110, "R10");
      // R3 / R6: enabled detects leave flags and pulse trap
      step(5'b00110, 1'b0, 1'b0, 6'b0, "R3");
      idle("R6");
      step(5'b00100, 1'b0, 1'b0, 6'b0, "R6");
      step(5'b00100, 1'b0, 1'b0, 6'b0, "R6");
      idle("R6");
      // R8: hardware set beats software clear
      step(5'b01001, 1'b1, 1'b0, 6'b000000, "R8");
      idle("R8");
      // R10: flag load of ones, mixed with enabled detect
      step(5'b00100, 1'b1, 1'b0, 6'b001010, "R10");
      // R2: underflow alone drives summary
      step(5'b0, 1'b1, 1'b0, 6'b0, "R5");
      step(5'b01000, 1'b0, 1'b0, 6'b0, "R2");
      // all enabled, all detected
      step(5'b0, 1'b0, 1'b1, 6'b011111, "R10");
      step(5'b11111, 1'b0, 1'b0, 6'b0, "R6");
      idle("R3");
      // all masked, all detected
      step(5'b0, 1'b1, 1'b1, 6'b0, "R10");
      step(5'b11111, 1'b0, 1'b0, 6'b0, "R9");
      idle("R4");
      idle("R4");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule